// File: doc/BRIEF.md
# Guest Trap Condition Evaluator

This block sits beside a processor core that runs guest code under a host monitor. Each cycle the core can present any mix of guest events: an instruction that may be forced out, an exception with its error code, an I/O port access, a model-specific register (MSR) read or write, a control register read or write, a task-priority register access, an external interrupt and the guest's own interrupt-enable level. The block checks each event against a configuration that the host has loaded: bitmaps, masks, shadow values and enable bits. From this it decides whether the guest must hand control back to the host.

The result is registered. One cycle after the events it shows an exit flag and a single reason code, picked by a fixed priority when several causes are true at once. When the guest reads a control register or the task-priority shadow, the same registered stage also returns the value the guest should see. Saving guest state, walking page tables and executing the instruction are left to the surrounding core.

Top module: `guest_trap_eval`

## Requirements
- R1: An instruction strobe whose code is one of the forced codes (0x08 and 0x37 by default) always exits with reason 1. Any other code causes no exit.
- R2: An exception whose vector is not the page-fault vector (14) exits with reason 2 exactly when the bit of `cfg_exc_bitmap` indexed by that vector is set.
- R3: A page fault (vector 14) exits with reason 2 exactly when `cfg_exc_bitmap[14]` equals the match result, where the match result is 1 when `(exc_err & cfg_pf_err_mask) == cfg_pf_err_match`.
- R4: An I/O access exits with reason 5 exactly when the bit of `cfg_io_bitmap` indexed by the port number is set.
- R5: An MSR read exits with reason 4 when its index bit in `cfg_msr_rd_bitmap` is set. An MSR write exits with reason 4 when its index bit in `cfg_msr_wr_bitmap` is set. The bitmap for the other direction has no effect.
- R6: A control register write exits with reason 3 exactly when `(cr_old ^ cr_new)` shares a set bit with that register's mask. The mask of register n is the field `cfg_cr_mask[n*CR_W +: CR_W]`. Writes that change only unmasked bits do not exit.
- R7: A control register read does not exit. It returns `obs_valid_o` = 1 and `obs_data_o` built from the shadow bits (field n of `cfg_cr_shadow`) where the mask is 1 and from `cr_old` where the mask is 0. When a control register read and a task-priority read come together, the control register value is returned.
- R8: With `cfg_ext_irq_exit` set, an external interrupt exits with reason 7 whatever `guest_irq_on` is. With it clear, an external interrupt causes no exit.
- R9: With `cfg_irq_window_exit` set, a 0-to-1 change of `guest_irq_on` exits with reason 8. A level that stays high or falls causes no exit.
- R10: With `cfg_tpr_shadow_en` set, a task-priority write stores `tpr_wdata` into the shadow copy without exiting, and a read returns the shadow, zero-extended, on `obs_data_o`. With it clear, any task-priority access exits with reason 6.
- R11: When several causes are true in the same cycle, the reason reported is the one with the lowest code, in the order 1 instruction, 2 exception, 3 control register, 4 MSR, 5 I/O, 6 task priority, 7 external interrupt, 8 interrupt window.
- R12: `exit_o`, `exit_reason_o` and `obs_valid_o` are registered. They reflect the events of one cycle on the next cycle and last only that cycle. Without events they are 0, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_exc_bitmap | input | NUM_VEC (32) | Exception exit bits, one per vector |
| cfg_pf_err_mask | input | ERR_W (5) | Page-fault error code bits to compare |
| cfg_pf_err_match | input | ERR_W (5) | Page-fault error code compare value |
| cfg_io_bitmap | input | 2**PORT_W (256) | I/O port exit bits |
| cfg_msr_rd_bitmap | input | 2**MSR_W (32) | MSR read exit bits |
| cfg_msr_wr_bitmap | input | 2**MSR_W (32) | MSR write exit bits |
| cfg_cr_mask | input | NUM_CR*CR_W (64) | Host-owned bit masks, one field per control register |
| cfg_cr_shadow | input | NUM_CR*CR_W (64) | Read shadows, one field per control register |
| cfg_ext_irq_exit | input | 1 | External interrupts exit |
| cfg_irq_window_exit | input | 1 | Exit when the guest enables interrupts |
| cfg_tpr_shadow_en | input | 1 | Route task-priority accesses to the shadow |
| ins_valid | input | 1 | Instruction strobe |
| ins_code | input | INS_W (8) | Instruction class code |
| exc_valid | input | 1 | Exception strobe |
| exc_vec | input | log2(NUM_VEC) (5) | Exception vector |
| exc_err | input | ERR_W (5) | Exception error code |
| io_valid | input | 1 | I/O access strobe |
| io_port | input | PORT_W (8) | I/O port number |
| msr_valid | input | 1 | MSR access strobe |
| msr_write | input | 1 | 1 = MSR write, 0 = read |
| msr_idx | input | MSR_W (5) | MSR index |
| cr_valid | input | 1 | Control register access strobe |
| cr_write | input | 1 | 1 = write, 0 = read |
| cr_idx | input | log2(NUM_CR) (2) | Control register number |
| cr_old | input | CR_W (16) | Current register value |
| cr_new | input | CR_W (16) | Value the guest writes |
| tpr_valid | input | 1 | Task-priority access strobe |
| tpr_write | input | 1 | 1 = write, 0 = read |
| tpr_wdata | input | TPR_W (4) | Task-priority write value |
| irq_ext | input | 1 | External interrupt arrival |
| guest_irq_on | input | 1 | Guest interrupt-enable level |
| exit_o | output | 1 | Exit to host |
| exit_reason_o | output | 4 | Reason code, 0 when no exit |
| obs_valid_o | output | 1 | Observed-value strobe |
| obs_data_o | output | CR_W (16) | Value returned to the guest read |

## Verification
Each event type is driven alone, once with a configuration bit that selects an exit and once with one that does not. This separates a bitmap that is indexed correctly from one whose index is off by one or whose direction is swapped. Page faults are tried with all four pairings of the bitmap bit and the error-code match, which shows whether the match result is honoured or inverted. Control register writes are tried with changes only in unmasked bits, in masked bits, with an all-zero mask and with an all-one mask. Reads are checked for the mix of shadow and real bits. Overlapping events are then driven in pairs, stepping down the priority chain, and the interrupt-enable level is driven through a rise, a hold and a fall, so that edge and level detection can be told apart.

// File: rtl/gte_pkg.sv
package gte_pkg;
   localparam int REASON_W = 4;
   localparam int CAUSE_N  = 8;

   typedef enum logic [REASON_W-1:0] {
      RSN_NONE   = 4'd0,
      RSN_INSTR  = 4'd1,
      RSN_EXC    = 4'd2,
      RSN_CREG   = 4'd3,
      RSN_MSR    = 4'd4,
      RSN_PORT   = 4'd5,
      RSN_TPRI   = 4'd6,
      RSN_EXTIRQ = 4'd7,
      RSN_IRQWIN = 4'd8
   } reason_e;
endpackage

// File: rtl/gte_bitmap_lookup.sv
module gte_bitmap_lookup #(
   parameter int IDX_W = 8
) (
   input  logic [(1<<IDX_W)-1:0] map,
   input  logic [IDX_W-1:0]      idx,
   input  logic                  valid,
   output logic                  hit
);
   assign hit = valid & map[idx];
endmodule

// File: rtl/gte_cr_guard.sv
module gte_cr_guard #(
   parameter int NUM_CR = 4,
   parameter int CR_W   = 16,
   localparam int CRI_W = $clog2(NUM_CR)
) (
   input  logic [NUM_CR*CR_W-1:0] mask_flat,
   input  logic [NUM_CR*CR_W-1:0] shadow_flat,
   input  logic [CRI_W-1:0]       idx,
   input  logic [CR_W-1:0]        old_val,
   input  logic [CR_W-1:0]        new_val,
   output logic                   touches_owned,
   output logic [CR_W-1:0]        guest_view
);
   logic [CR_W-1:0] mask_a   [NUM_CR];
   logic [CR_W-1:0] shadow_a [NUM_CR];

   for (genvar n = 0; n < NUM_CR; n++) begin : g_unpack
      assign mask_a[n]   = mask_flat[n*CR_W +: CR_W];
      assign shadow_a[n] = shadow_flat[n*CR_W +: CR_W];
   end

   logic [CR_W-1:0] sel_mask, sel_shadow;
   assign sel_mask   = mask_a[idx];
   assign sel_shadow = shadow_a[idx];

   assign touches_owned = |((old_val ^ new_val) & sel_mask);
   assign guest_view    = (sel_shadow & sel_mask) | (old_val & ~sel_mask);
endmodule

// File: rtl/gte_irq_watch.sv
module gte_irq_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_ext,
   input  logic guest_on,
   input  logic ext_en,
   input  logic win_en,
   output logic ext_cause,
   output logic win_cause
);
   logic on_q;

   always_ff @(posedge clk) begin
      if (!rst_n) on_q <= 1'b0;
      else        on_q <= guest_on;
   end

   assign ext_cause = ext_en & irq_ext;
   assign win_cause = win_en & guest_on & ~on_q;
endmodule

// File: rtl/gte_prio_enc.sv
module gte_prio_enc #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [N-1:0] seen;
   logic [N-1:0] sel;

   assign seen[0] = 1'b0;
   for (genvar i = 1; i < N; i++) begin : g_chain
      assign seen[i] = seen[i-1] | req[i-1];
   end
   for (genvar i = 0; i < N; i++) begin : g_sel
      assign sel[i] = req[i] & ~seen[i];
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (sel[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/guest_trap_eval.sv
module guest_trap_eval
   import gte_pkg::*;
#(
   parameter int NUM_VEC    = 32,
   parameter int PF_VEC     = 14,
   parameter int ERR_W      = 5,
   parameter int PORT_W     = 8,
   parameter int MSR_W      = 5,
   parameter int NUM_CR     = 4,
   parameter int CR_W       = 16,
   parameter int TPR_W      = 4,
   parameter int INS_W      = 8,
   parameter int NUM_FORCED = 2,
   parameter logic [NUM_FORCED*INS_W-1:0] FORCED_CODES = {8'h37, 8'h08}
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_VEC-1:0]           cfg_exc_bitmap,
   input  logic [ERR_W-1:0]             cfg_pf_err_mask,
   input  logic [ERR_W-1:0]             cfg_pf_err_match,
   input  logic [(1<<PORT_W)-1:0]       cfg_io_bitmap,
   input  logic [(1<<MSR_W)-1:0]        cfg_msr_rd_bitmap,
   input  logic [(1<<MSR_W)-1:0]        cfg_msr_wr_bitmap,
   input  logic [NUM_CR*CR_W-1:0]       cfg_cr_mask,
   input  logic [NUM_CR*CR_W-1:0]       cfg_cr_shadow,
   input  logic                         cfg_ext_irq_exit,
   input  logic                         cfg_irq_window_exit,
   input  logic                         cfg_tpr_shadow_en,
   input  logic                         ins_valid,
   input  logic [INS_W-1:0]             ins_code,
   input  logic                         exc_valid,
   input  logic [$clog2(NUM_VEC)-1:0]   exc_vec,
   input  logic [ERR_W-1:0]             exc_err,
   input  logic                         io_valid,
   input  logic [PORT_W-1:0]            io_port,
   input  logic                         msr_valid,
   input  logic                         msr_write,
   input  logic [MSR_W-1:0]             msr_idx,
   input  logic                         cr_valid,
   input  logic                         cr_write,
   input  logic [$clog2(NUM_CR)-1:0]    cr_idx,
   input  logic [CR_W-1:0]              cr_old,
   input  logic [CR_W-1:0]              cr_new,
   input  logic                         tpr_valid,
   input  logic                         tpr_write,
   input  logic [TPR_W-1:0]             tpr_wdata,
   input  logic                         irq_ext,
   input  logic                         guest_irq_on,
   output logic                         exit_o,
   output logic [3:0]                   exit_reason_o,
   output logic                         obs_valid_o,
   output logic [CR_W-1:0]              obs_data_o
);
   localparam int VEC_W = $clog2(NUM_VEC);
   localparam int PIW   = $clog2(CAUSE_N);

   // elaboration-time parameter checks
   if (NUM_VEC < 2 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_vec
      $error("NUM_VEC must be a power of two, at least 2");
   end
   if (PF_VEC < 0 || PF_VEC >= NUM_VEC) begin : g_bad_pf
      $error("PF_VEC must index a bit of the exception bitmap");
   end
   if (NUM_CR < 2 || (NUM_CR & (NUM_CR - 1)) != 0) begin : g_bad_cr
      $error("NUM_CR must be a power of two, at least 2");
   end
   if (TPR_W < 1 || TPR_W > CR_W) begin : g_bad_tpr
      $error("TPR_W must lie between 1 and CR_W");
   end
   if (PORT_W < 1 || PORT_W > 16 || MSR_W < 1 || MSR_W > 12) begin : g_bad_map
      $error("bitmap index widths out of range");
   end
   if (NUM_FORCED < 1) begin : g_bad_forced
      $error("at least one forced instruction code is required");
   end

   // unconditional instruction exits
   logic [NUM_FORCED-1:0] forced_hit;
   for (genvar k = 0; k < NUM_FORCED; k++) begin : g_forced
      assign forced_hit[k] = (ins_code == FORCED_CODES[k*INS_W +: INS_W]);
   end
   logic cause_ins;
   assign cause_ins = ins_valid & (|forced_hit);

   // exceptions, with page faults qualified by the error code
   logic is_pf, pf_qual, exc_plain_hit, cause_exc;
   assign is_pf   = exc_valid & (exc_vec == VEC_W'(PF_VEC));
   assign pf_qual = ((exc_err & cfg_pf_err_mask) == cfg_pf_err_match);

   gte_bitmap_lookup #(.IDX_W(VEC_W)) u_exc_lkp (
      .map   (cfg_exc_bitmap),
      .idx   (exc_vec),
      .valid (exc_valid & ~is_pf),
      .hit   (exc_plain_hit)
   );
   assign cause_exc = exc_plain_hit | (is_pf & (cfg_exc_bitmap[PF_VEC] == pf_qual));

   // I/O ports
   logic cause_io;
   gte_bitmap_lookup #(.IDX_W(PORT_W)) u_io_lkp (
      .map   (cfg_io_bitmap),
      .idx   (io_port),
      .valid (io_valid),
      .hit   (cause_io)
   );

   // MSR accesses, one bitmap per direction
   logic msr_rd_hit, msr_wr_hit, cause_msr;
   gte_bitmap_lookup #(.IDX_W(MSR_W)) u_msr_rd_lkp (
      .map   (cfg_msr_rd_bitmap),
      .idx   (msr_idx),
      .valid (msr_valid & ~msr_write),
      .hit   (msr_rd_hit)
   );
   gte_bitmap_lookup #(.IDX_W(MSR_W)) u_msr_wr_lkp (
      .map   (cfg_msr_wr_bitmap),
      .idx   (msr_idx),
      .valid (msr_valid & msr_write),
      .hit   (msr_wr_hit)
   );
   assign cause_msr = msr_rd_hit | msr_wr_hit;

   // control registers
   logic            cr_touch;
   logic [CR_W-1:0] cr_view;
   gte_cr_guard #(.NUM_CR(NUM_CR), .CR_W(CR_W)) u_cr_guard (
      .mask_flat     (cfg_cr_mask),
      .shadow_flat   (cfg_cr_shadow),
      .idx           (cr_idx),
      .old_val       (cr_old),
      .new_val       (cr_new),
      .touches_owned (cr_touch),
      .guest_view    (cr_view)
   );
   logic cause_cr, cr_read;
   assign cause_cr = cr_valid & cr_write & cr_touch;
   assign cr_read  = cr_valid & ~cr_write;

   // task-priority shadow copy
   logic [TPR_W-1:0] tpr_q;
   logic             cause_tpr, tpr_read;
   always_ff @(posedge clk) begin
      if (!rst_n)
         tpr_q <= '0;
      else if (tpr_valid & tpr_write & cfg_tpr_shadow_en)
         tpr_q <= tpr_wdata;
   end
   assign cause_tpr = tpr_valid & ~cfg_tpr_shadow_en;
   assign tpr_read  = tpr_valid & ~tpr_write & cfg_tpr_shadow_en;

   // interrupts
   logic cause_ext, cause_win;
   gte_irq_watch u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_ext   (irq_ext),
      .guest_on  (guest_irq_on),
      .ext_en    (cfg_ext_irq_exit),
      .win_en    (cfg_irq_window_exit),
      .ext_cause (cause_ext),
      .win_cause (cause_win)
   );

   // priority: bit 0 wins
   logic [CAUSE_N-1:0] causes;
   assign causes = {cause_win, cause_ext, cause_tpr, cause_io,
                    cause_msr, cause_cr, cause_exc, cause_ins};

   logic           any_cause;
   logic [PIW-1:0] win_idx;
   gte_prio_enc #(.N(CAUSE_N)) u_prio (
      .req (causes),
      .any (any_cause),
      .idx (win_idx)
   );

   reason_e reason_d;
   assign reason_d = any_cause ? reason_e'(REASON_W'(win_idx) + REASON_W'(1)) : RSN_NONE;

   logic [CR_W-1:0] obs_d;
   assign obs_d = cr_read  ? cr_view :
                  tpr_read ? CR_W'(tpr_q) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exit_o        <= 1'b0;
         exit_reason_o <= RSN_NONE;
         obs_valid_o   <= 1'b0;
         obs_data_o    <= '0;
      end else begin
         exit_o        <= any_cause;
         exit_reason_o <= reason_d;
         obs_valid_o   <= cr_read | tpr_read;
         obs_data_o    <= obs_d;
      end
   end
endmodule

// File: rtl/guest_trap_eval_chk.sv
module guest_trap_eval_chk
   import gte_pkg::*;
#(
   parameter int NUM_CR     = 4,
   parameter int CR_W       = 16,
   parameter int INS_W      = 8,
   parameter int NUM_FORCED = 2,
   parameter logic [NUM_FORCED*INS_W-1:0] FORCED_CODES = {8'h37, 8'h08}
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ins_valid,
   input logic [INS_W-1:0]          ins_code,
   input logic                      exc_valid,
   input logic                      io_valid,
   input logic                      msr_valid,
   input logic                      cr_valid,
   input logic                      cr_write,
   input logic [$clog2(NUM_CR)-1:0] cr_idx,
   input logic [CR_W-1:0]           cr_old,
   input logic [CR_W-1:0]           cr_new,
   input logic [NUM_CR*CR_W-1:0]    cfg_cr_mask,
   input logic [NUM_CR*CR_W-1:0]    cfg_cr_shadow,
   input logic                      tpr_valid,
   input logic                      irq_ext,
   input logic                      cfg_ext_irq_exit,
   input logic                      cfg_irq_window_exit,
   input logic                      exit_o,
   input logic [3:0]                exit_reason_o,
   input logic                      obs_valid_o,
   input logic [CR_W-1:0]           obs_data_o
);
   logic is_forced;
   always_comb begin
      is_forced = 1'b0;
      for (int k = 0; k < NUM_FORCED; k++)
         if (ins_code == FORCED_CODES[k*INS_W +: INS_W]) is_forced = 1'b1;
   end

   logic [CR_W-1:0] msk, shd;
   assign msk = cfg_cr_mask[cr_idx*CR_W +: CR_W];
   assign shd = cfg_cr_shadow[cr_idx*CR_W +: CR_W];

   logic quiet;
   assign quiet = !ins_valid && !exc_valid && !io_valid && !msr_valid &&
                  !cr_valid && !tpr_valid && !irq_ext && !cfg_irq_window_exit;

   assert_forced_instr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && is_forced |=> exit_o && exit_reason_o == RSN_INSTR);

   assert_cr_owned_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cr_valid && cr_write && !ins_valid && !exc_valid && ((cr_old ^ cr_new) & msk) != '0
      |=> exit_o && exit_reason_o == RSN_CREG);

   assert_cr_read_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cr_valid && !cr_write |=> obs_valid_o
         && ((obs_data_o ^ $past(cr_old)) & ~$past(msk)) == '0
         && ((obs_data_o ^ $past(shd)) & $past(msk)) == '0);

   assert_ext_irq_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ext && cfg_ext_irq_exit |=> exit_o);

   assert_reason_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      exit_o |-> exit_reason_o >= 4'd1 && exit_reason_o <= 4'd8);

   assert_quiet_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> !exit_o && !obs_valid_o && exit_reason_o == RSN_NONE);
endmodule

bind guest_trap_eval guest_trap_eval_chk #(
   .NUM_CR(NUM_CR), .CR_W(CR_W), .INS_W(INS_W),
   .NUM_FORCED(NUM_FORCED), .FORCED_CODES(FORCED_CODES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_code(ins_code),
   .exc_valid(exc_valid), .io_valid(io_valid), .msr_valid(msr_valid),
   .cr_valid(cr_valid), .cr_write(cr_write), .cr_idx(cr_idx),
   .cr_old(cr_old), .cr_new(cr_new), .cfg_cr_mask(cfg_cr_mask),
   .cfg_cr_shadow(cfg_cr_shadow), .tpr_valid(tpr_valid), .irq_ext(irq_ext),
   .cfg_ext_irq_exit(cfg_ext_irq_exit), .cfg_irq_window_exit(cfg_irq_window_exit),
   .exit_o(exit_o), .exit_reason_o(exit_reason_o),
   .obs_valid_o(obs_valid_o), .obs_data_o(obs_data_o)
);

// File: tb/guest_trap_eval_tb_top.sv
`timescale 1ns/1ps
module guest_trap_eval_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [31:0] cfg_exc_bitmap;
   logic [4:0]  cfg_pf_err_mask, cfg_pf_err_match;
   logic [255:0] cfg_io_bitmap;
   logic [31:0] cfg_msr_rd_bitmap, cfg_msr_wr_bitmap;
   logic [63:0] cfg_cr_mask, cfg_cr_shadow;
   logic        cfg_ext_irq_exit, cfg_irq_window_exit, cfg_tpr_shadow_en;
   logic        ins_valid;  logic [7:0] ins_code;
   logic        exc_valid;  logic [4:0] exc_vec; logic [4:0] exc_err;
   logic        io_valid;   logic [7:0] io_port;
   logic        msr_valid, msr_write; logic [4:0] msr_idx;
   logic        cr_valid, cr_write; logic [1:0] cr_idx; logic [15:0] cr_old, cr_new;
   logic        tpr_valid, tpr_write; logic [3:0] tpr_wdata;
   logic        irq_ext, guest_irq_on;
   logic        exit_o; logic [3:0] exit_reason_o; logic obs_valid_o; logic [15:0] obs_data_o;

   guest_trap_eval dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_exc_bitmap(cfg_exc_bitmap), .cfg_pf_err_mask(cfg_pf_err_mask),
      .cfg_pf_err_match(cfg_pf_err_match), .cfg_io_bitmap(cfg_io_bitmap),
      .cfg_msr_rd_bitmap(cfg_msr_rd_bitmap), .cfg_msr_wr_bitmap(cfg_msr_wr_bitmap),
      .cfg_cr_mask(cfg_cr_mask), .cfg_cr_shadow(cfg_cr_shadow),
      .cfg_ext_irq_exit(cfg_ext_irq_exit), .cfg_irq_window_exit(cfg_irq_window_exit),
      .cfg_tpr_shadow_en(cfg_tpr_shadow_en),
      .ins_valid(ins_valid), .ins_code(ins_code),
      .exc_valid(exc_valid), .exc_vec(exc_vec), .exc_err(exc_err),
      .io_valid(io_valid), .io_port(io_port),
      .msr_valid(msr_valid), .msr_write(msr_write), .msr_idx(msr_idx),
      .cr_valid(cr_valid), .cr_write(cr_write), .cr_idx(cr_idx),
      .cr_old(cr_old), .cr_new(cr_new),
      .tpr_valid(tpr_valid), .tpr_write(tpr_write), .tpr_wdata(tpr_wdata),
      .irq_ext(irq_ext), .guest_irq_on(guest_irq_on),
      .exit_o(exit_o), .exit_reason_o(exit_reason_o),
      .obs_valid_o(obs_valid_o), .obs_data_o(obs_data_o)
   );

   typedef struct {
      logic        ex;
      logic [3:0]  rsn;
      logic        ov;
      logic [15:0] od;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t mon_e;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;
   logic       m_prev_on = 1'b0;
   logic [3:0] m_tpr = 4'h0;

   task automatic clear_ev();
      ins_valid = 0; ins_code = 0; exc_valid = 0; exc_vec = 0; exc_err = 0;
      io_valid = 0; io_port = 0; msr_valid = 0; msr_write = 0; msr_idx = 0;
      cr_valid = 0; cr_write = 0; cr_idx = 0; cr_old = 0; cr_new = 0;
      tpr_valid = 0; tpr_write = 0; tpr_wdata = 0; irq_ext = 0;
   endtask

   // driver side: expected result from the requirements for the inputs now applied
   task automatic commit(string tag);
      exp_t e;
      logic [7:0] c;
      logic [15:0] m, s;
      logic pfq;
      m = cfg_cr_mask[cr_idx*16 +: 16];
      s = cfg_cr_shadow[cr_idx*16 +: 16];
      pfq = ((exc_err & cfg_pf_err_mask) == cfg_pf_err_match);
      c[0] = ins_valid && (ins_code == 8'h08 || ins_code == 8'h37);
      c[1] = exc_valid && ((exc_vec == 5'd14) ? (cfg_exc_bitmap[14] == pfq) : cfg_exc_bitmap[exc_vec]);
      c[2] = cr_valid && cr_write && (((cr_old ^ cr_new) & m) != 16'h0);
      c[3] = msr_valid && (msr_write ? cfg_msr_wr_bitmap[msr_idx] : cfg_msr_rd_bitmap[msr_idx]);
      c[4] = io_valid && cfg_io_bitmap[io_port];
      c[5] = tpr_valid && !cfg_tpr_shadow_en;
      c[6] = irq_ext && cfg_ext_irq_exit;
      c[7] = cfg_irq_window_exit && guest_irq_on && !m_prev_on;
      e.ex = |c; e.rsn = 4'd0;
      for (int i = 7; i >= 0; i--) if (c[i]) e.rsn = 4'(i + 1);
      e.ov = 1'b0; e.od = 16'h0;
      if (cr_valid && !cr_write) begin
         e.ov = 1'b1; e.od = (s & m) | (cr_old & ~m);
      end else if (tpr_valid && !tpr_write && cfg_tpr_shadow_en) begin
         e.ov = 1'b1; e.od = {12'h0, m_tpr};
      end
      e.tag = tag;
      sb_q.push_back(e);
      m_prev_on = guest_irq_on;
      if (tpr_valid && tpr_write && cfg_tpr_shadow_en) m_tpr = tpr_wdata;
   endtask

   // monitor side: compare the registered outputs one cycle after the events
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         mon_e = sb_q.pop_front();
         n_chk++;
         if (exit_o !== mon_e.ex || exit_reason_o !== mon_e.rsn || obs_valid_o !== mon_e.ov ||
             (mon_e.ov && obs_data_o !== mon_e.od)) begin
            n_fail++;
            $display("FAIL %s: got exit=%0b reason=%0d obs_v=%0b obs=%h, expected exit=%0b reason=%0d obs_v=%0b obs=%h",
                     mon_e.tag, exit_o, exit_reason_o, obs_valid_o, obs_data_o,
                     mon_e.ex, mon_e.rsn, mon_e.ov, mon_e.od);
         end
      end
   end

   task automatic idle(string tag);
      @(negedge clk); clear_ev(); commit(tag);
   endtask
   task automatic do_ins(logic [7:0] code, string tag);
      @(negedge clk); clear_ev(); ins_valid = 1; ins_code = code; commit(tag);
   endtask
   task automatic do_exc(logic [4:0] v, logic [4:0] err, string tag);
      @(negedge clk); clear_ev(); exc_valid = 1; exc_vec = v; exc_err = err; commit(tag);
   endtask
   task automatic do_io(logic [7:0] p, string tag);
      @(negedge clk); clear_ev(); io_valid = 1; io_port = p; commit(tag);
   endtask
   task automatic do_msr(logic wr, logic [4:0] idx, string tag);
      @(negedge clk); clear_ev(); msr_valid = 1; msr_write = wr; msr_idx = idx; commit(tag);
   endtask
   task automatic do_cr(logic wr, logic [1:0] idx, logic [15:0] o, logic [15:0] n, string tag);
      @(negedge clk); clear_ev(); cr_valid = 1; cr_write = wr; cr_idx = idx;
      cr_old = o; cr_new = n; commit(tag);
   endtask
   task automatic do_tpr(logic wr, logic [3:0] d, string tag);
      @(negedge clk); clear_ev(); tpr_valid = 1; tpr_write = wr; tpr_wdata = d; commit(tag);
   endtask

   initial begin
      rst_n = 0;
      clear_ev();
      guest_irq_on = 0;
      cfg_exc_bitmap = 32'h0;
      cfg_exc_bitmap[3] = 1; cfg_exc_bitmap[13] = 1; cfg_exc_bitmap[14] = 1;
      cfg_pf_err_mask = 5'b00011; cfg_pf_err_match = 5'b00001;
      cfg_io_bitmap = '0; cfg_io_bitmap[8'h60] = 1; cfg_io_bitmap[8'hFF] = 1;
      cfg_msr_rd_bitmap = 32'h0; cfg_msr_rd_bitmap[5] = 1;
      cfg_msr_wr_bitmap = 32'h0; cfg_msr_wr_bitmap[9] = 1;
      cfg_cr_mask   = {16'h8001, 16'h0000, 16'hFFFF, 16'h00F0};
      cfg_cr_shadow = {16'h8000, 16'h1234, 16'hABCD, 16'h0050};
      cfg_ext_irq_exit = 0; cfg_irq_window_exit = 0; cfg_tpr_shadow_en = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #2;
      n_chk++;
      if (exit_o !== 1'b0 || exit_reason_o !== 4'd0 || obs_valid_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R12 reset: got exit=%0b reason=%0d obs_v=%0b, expected 0 0 0",
                  exit_o, exit_reason_o, obs_valid_o);
      end

      // R1
      do_ins(8'h08, "R1 forced 08"); do_ins(8'h37, "R1 forced 37");
      do_ins(8'h09, "R1 plain code"); idle("R12 idle after exit");
      // R2
      do_exc(5'd3, 5'd0, "R2 vec3 set"); do_exc(5'd4, 5'd0, "R2 vec4 clear");
      do_exc(5'd13, 5'd7, "R2 vec13 set");
      // R3
      do_exc(5'd14, 5'b00001, "R3 bit1 match");
      do_exc(5'd14, 5'b00011, "R3 bit1 nomatch");
      @(negedge clk); cfg_exc_bitmap[14] = 0;
      clear_ev(); commit("R12 idle");
      do_exc(5'd14, 5'b00011, "R3 bit0 nomatch");
      do_exc(5'd14, 5'b00101, "R3 bit0 match");
      // R4
      do_io(8'h60, "R4 port 60"); do_io(8'h61, "R4 port 61"); do_io(8'hFF, "R4 port FF");
      // R5
      do_msr(0, 5'd5, "R5 rd 5"); do_msr(1, 5'd5, "R5 wr 5");
      do_msr(1, 5'd9, "R5 wr 9"); do_msr(0, 5'd9, "R5 rd 9");
      // R6
      do_cr(1, 2'd0, 16'h0050, 16'h015F, "R6 unmasked only");
      do_cr(1, 2'd0, 16'h0050, 16'h0060, "R6 masked change");
      do_cr(1, 2'd2, 16'h0000, 16'hFFFF, "R6 zero mask");
      do_cr(1, 2'd1, 16'h0000, 16'h0100, "R6 full mask");
      do_cr(1, 2'd3, 16'h0000, 16'h8000, "R6 top bit");
      do_cr(1, 2'd3, 16'h0000, 16'h0002, "R6 cr3 free bit");
      // R7
      do_cr(0, 2'd0, 16'h1234, 16'h0000, "R7 read cr0");
      do_cr(0, 2'd1, 16'h5555, 16'h0000, "R7 read cr1");
      do_cr(0, 2'd3, 16'h7FFE, 16'h0000, "R7 read cr3");
      // R8
      @(negedge clk); clear_ev(); cfg_ext_irq_exit = 1; irq_ext = 1; commit("R8 ext guest off");
      @(negedge clk); clear_ev(); guest_irq_on = 1; cfg_irq_window_exit = 0; irq_ext = 1; commit("R8 ext guest on");
      @(negedge clk); clear_ev(); cfg_ext_irq_exit = 0; irq_ext = 1; commit("R8 ext disabled");
      // R9
      @(negedge clk); clear_ev(); guest_irq_on = 0; cfg_irq_window_exit = 1; commit("R9 masked");
      @(negedge clk); clear_ev(); guest_irq_on = 1; commit("R9 rise");
      idle("R9 hold high");
      @(negedge clk); clear_ev(); guest_irq_on = 0; commit("R9 fall");
      @(negedge clk); clear_ev(); cfg_irq_window_exit = 0; commit("R12 idle");
      // R10
      do_tpr(1, 4'h9, "R10 shadow write"); do_tpr(0, 4'h0, "R10 shadow read");
      do_tpr(1, 4'h3, "R10 shadow write 2"); do_tpr(0, 4'h0, "R10 shadow read 2");
      @(negedge clk); cfg_tpr_shadow_en = 0; clear_ev(); commit("R12 idle");
      do_tpr(0, 4'h0, "R10 read no shadow"); do_tpr(1, 4'hF, "R10 write no shadow");
      @(negedge clk); cfg_tpr_shadow_en = 1; clear_ev(); commit("R12 idle");
      do_tpr(0, 4'h0, "R10 shadow kept");
      // R11 priority pairs
      @(negedge clk); clear_ev(); ins_valid = 1; ins_code = 8'h08; exc_valid = 1; exc_vec = 5'd3;
      cr_valid = 1; cr_write = 1; cr_idx = 2'd1; cr_new = 16'h1; msr_valid = 1; msr_idx = 5'd5;
      io_valid = 1; io_port = 8'h60; commit("R11 all");
      @(negedge clk); clear_ev(); exc_valid = 1; exc_vec = 5'd3;
      cr_valid = 1; cr_write = 1; cr_idx = 2'd1; cr_new = 16'h1; commit("R11 exc over cr");
      @(negedge clk); clear_ev(); cr_valid = 1; cr_write = 1; cr_idx = 2'd1; cr_new = 16'h1;
      msr_valid = 1; msr_write = 1; msr_idx = 5'd9; commit("R11 cr over msr");
      @(negedge clk); clear_ev(); msr_valid = 1; msr_idx = 5'd5; io_valid = 1; io_port = 8'hFF;
      commit("R11 msr over io");
      @(negedge clk); clear_ev(); cfg_tpr_shadow_en = 0; io_valid = 1; io_port = 8'h60;
      tpr_valid = 1; commit("R11 io over tpr");
      @(negedge clk); clear_ev(); tpr_valid = 1; cfg_ext_irq_exit = 1; irq_ext = 1;
      commit("R11 tpr over ext");
      @(negedge clk); clear_ev(); cfg_tpr_shadow_en = 1; cfg_irq_window_exit = 1; guest_irq_on = 1;
      irq_ext = 1; commit("R11 ext over window");
      @(negedge clk); clear_ev(); cfg_ext_irq_exit = 0; guest_irq_on = 0; commit("R12 idle");
      @(negedge clk); clear_ev(); guest_irq_on = 1; ins_valid = 1; ins_code = 8'h11; commit("R11 window alone");
      @(negedge clk); clear_ev(); cfg_irq_window_exit = 0; cr_valid = 1; cr_idx = 2'd2; cr_old = 16'hBEEF;
      tpr_valid = 1; commit("R7 cr read over tpr read");
      idle("R12 idle end"); idle("R12 idle end");
      repeat (3) @(posedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R12 watchdog: got no completion, expected end of sequence");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule